// File: doc/BRIEF.md
# First-Hit Channel Address Serializer

This block watches a bank of channel hit strobes and latches the index of the first channel that fires while it is armed. It then sends that index on one serial line, clocked by a dedicated fast clock. The frame is a single high start flag followed by the channel address, most significant bit first. Downstream logic can therefore learn where activity happened as soon as it happens, without waiting for a trigger or a full readout.

When the frame ends, the block waits through a fixed recovery interval. It then rearms and raises its ready output again. Any hit that arrives while the block is sending or recovering is dropped. In the default build the line carries one bit in the high phase of each clock and one in the low phase, so every clock edge shifts a new bit. A parameter selects a variant that sends one bit per clock instead. The captured address is also presented in parallel on a debug output.

Top module: `first_hit_addr_ser`

## Requirements
- R1: During and straight after reset, ready is high, the serial line is low and the debug address is zero.
- R2: While ready is high, a clock edge that samples at least one hit strobe high captures an address, and ready is low from that edge on.
- R3: When several strobes are high at the capturing edge, the captured address is the lowest index among them.
- R4: The frame has 8 half-cycle slots, in this order: flag (1), then address bits 5 down to 0, then one low pad slot. The flag appears in the high clock phase of the cycle that follows the capture edge. Each later slot takes the next clock phase.
- R5: The serial line is low whenever no frame is being sent.
- R6: Hit strobes sampled while ready is low start no frame and leave the debug address unchanged.
- R7: After a capture edge, ready stays low for exactly SEND_CYC + REARM_CYC clock cycles. That is 4 + 4 = 8 with the default parameters. It then returns high, and the next hit is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dedicated serializer clock; both phases carry data in DDR mode |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit | input | N_CH | Per-channel hit strobes, sampled on the rising edge |
| ser_out | output | 1 | Serial flag-and-address line |
| ready | output | 1 | High while armed and waiting for a hit |
| dbg_addr | output | AW | Most recently captured channel address (parallel debug copy) |

## Verification
The bench builds the block with N_CH=64, REARM_CYC=4 and DDR_EN=1. The full six-bit address range is therefore in play, so channel 0, channel 63 and patterns with mixed high and low address bits can all be framed. With the short recovery, the busy window is only eight cycles. This lets the bench land discarded strobes both during the send phase and during the recovery phase, and then measure the exact moment of rearm.

// File: rtl/fhs_pkg.sv
package fhs_pkg;
    typedef enum logic [1:0] {
        ST_ARMED   = 2'd0,
        ST_SEND    = 2'd1,
        ST_RECOVER = 2'd2
    } fhs_state_e;
endpackage

// File: rtl/fhs_lowest_pick.sv
module fhs_lowest_pick #(
    parameter int N_CH = 64,
    localparam int AW = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic [N_CH-1:0] hit,
    output logic            any_hit,
    output logic [AW-1:0]   pick
);
    // Scan from the top so the lowest set index is written last and wins.
    always_comb begin
        pick = '0;
        for (int i = N_CH - 1; i >= 0; i--) begin
            if (hit[i]) pick = AW'(i);
        end
    end

    assign any_hit = |hit;
endmodule

// File: rtl/fhs_line_drive.sv
module fhs_line_drive #(
    parameter bit DDR_EN = 1'b1
) (
    input  logic clk,
    input  logic active,
    input  logic bit_hi,
    input  logic bit_lo,
    output logic line
);
    generate
        if (DDR_EN) begin : g_ddr
            // High phase carries the earlier slot, low phase the later one.
            assign line = active & (clk ? bit_hi : bit_lo);
        end else begin : g_sdr
            assign line = active & bit_hi;
        end
    endgenerate
endmodule

// File: rtl/first_hit_addr_ser.sv
module first_hit_addr_ser
    import fhs_pkg::*;
#(
    parameter int N_CH      = 64,
    parameter int REARM_CYC = 4,
    parameter bit DDR_EN    = 1'b1,
    localparam int AW = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] hit,
    output logic            ser_out,
    output logic            ready,
    output logic [AW-1:0]   dbg_addr
);
    localparam int FRAME_W  = 1 + AW;
    localparam int SLOTS    = DDR_EN ? (FRAME_W + (FRAME_W % 2)) : FRAME_W;
    localparam int STEP     = DDR_EN ? 2 : 1;
    localparam int SEND_CYC = SLOTS / STEP;
    localparam int MAXC     = (SEND_CYC > REARM_CYC) ? SEND_CYC : REARM_CYC;
    localparam int CW       = $clog2(MAXC + 1);

    typedef struct packed {
        fhs_state_e       st;
        logic [SLOTS-1:0] sreg;
        logic [CW-1:0]    cnt;
        logic [AW-1:0]    addr;
    } fhs_regs_t;

    fhs_regs_t regs_d, regs_q;

    logic          any_hit;
    logic [AW-1:0] pick;

    fhs_lowest_pick #(.N_CH(N_CH)) u_pick (
        .hit     (hit),
        .any_hit (any_hit),
        .pick    (pick)
    );

    always_comb begin
        regs_d = regs_q;
        unique case (regs_q.st)
            ST_ARMED: begin
                if (any_hit) begin
                    regs_d.st   = ST_SEND;
                    regs_d.addr = pick;
                    regs_d.sreg = SLOTS'({1'b1, pick}) << (SLOTS - FRAME_W);
                    regs_d.cnt  = CW'(SEND_CYC - 1);
                end
            end
            ST_SEND: begin
                if (regs_q.cnt == '0) begin
                    regs_d.st   = ST_RECOVER;
                    regs_d.sreg = '0;
                    regs_d.cnt  = CW'(REARM_CYC - 1);
                end else begin
                    regs_d.sreg = regs_q.sreg << STEP;
                    regs_d.cnt  = regs_q.cnt - 1'b1;
                end
            end
            ST_RECOVER: begin
                if (regs_q.cnt == '0) begin
                    regs_d.st = ST_ARMED;
                end else begin
                    regs_d.cnt = regs_q.cnt - 1'b1;
                end
            end
            default: regs_d.st = ST_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.st   <= ST_ARMED;
            regs_q.sreg <= '0;
            regs_q.cnt  <= '0;
            regs_q.addr <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    fhs_line_drive #(.DDR_EN(DDR_EN)) u_line (
        .clk    (clk),
        .active (regs_q.st == ST_SEND),
        .bit_hi (regs_q.sreg[SLOTS-1]),
        .bit_lo (regs_q.sreg[SLOTS-2]),
        .line   (ser_out)
    );

    assign ready    = (regs_q.st == ST_ARMED);
    assign dbg_addr = regs_q.addr;
endmodule

// File: rtl/fhs_checker.sv
module fhs_checker #(
    parameter int N_CH      = 64,
    parameter int REARM_CYC = 4,
    parameter bit DDR_EN    = 1'b1,
    localparam int AW = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N_CH-1:0] hit,
    input logic            ser_out,
    input logic            ready,
    input logic [AW-1:0]   dbg_addr,
    input logic            any_hit,
    input logic [AW-1:0]   pick
);
    localparam int FRAME_W  = 1 + AW;
    localparam int SLOTS    = DDR_EN ? (FRAME_W + (FRAME_W % 2)) : FRAME_W;
    localparam int SEND_CYC = DDR_EN ? SLOTS / 2 : SLOTS;
    localparam int TOT      = SEND_CYC + REARM_CYC;

    logic [15:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               busy_cnt <= '0;
        else if (ready)           busy_cnt <= '0;
        else if (busy_cnt != '1)  busy_cnt <= busy_cnt + 1'b1;
    end

    // R2
    capture_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && any_hit) |=> !ready);

    // R3
    lowest_index_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |-> (hit[pick] && ((hit & ((N_CH'(1) << pick) - 1'b1)) == '0)));

    // R5
    idle_line_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !ser_out);

    // R6
    busy_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && $past(!ready)) |-> $stable(dbg_addr));

    // R7
    rearm_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (busy_cnt == 16'(TOT)));
endmodule

bind first_hit_addr_ser fhs_checker #(
    .N_CH      (N_CH),
    .REARM_CYC (REARM_CYC),
    .DDR_EN    (DDR_EN)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit      (hit),
    .ser_out  (ser_out),
    .ready    (ready),
    .dbg_addr (dbg_addr),
    .any_hit  (any_hit),
    .pick     (pick)
);

// File: tb/first_hit_addr_ser_bench.sv
module first_hit_addr_ser_bench;
    localparam int N_CH      = 64;
    localparam int AW        = 6;
    localparam int REARM_CYC = 4;
    localparam int BUSY_CYC  = 4 + REARM_CYC;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N_CH-1:0] hit = '0;
    logic            ser_out;
    logic            ready;
    logic [AW-1:0]   dbg_addr;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    logic [AW-1:0] exp_q[$];
    string         tag_q[$];

    always #10 clk = ~clk;

    first_hit_addr_ser #(.N_CH(N_CH), .REARM_CYC(REARM_CYC), .DDR_EN(1'b1)) u_first_hit_addr_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .ser_out  (ser_out),
        .ready    (ready),
        .dbg_addr (dbg_addr)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: rebuilds frames from half-cycle samples and compares them.
    bit       coll = 1'b0;
    int       nb   = 0;
    logic [7:0] fr = '0;

    task automatic take_bit(input logic v);
        logic [7:0] expf;
        if (!coll) begin
            if (v === 1'b1) begin
                coll = 1'b1;
                fr   = 8'b1000_0000;
                nb   = 1;
            end
        end else begin
            fr[7-nb] = v;
            nb++;
            if (nb == 8) begin
                coll = 1'b0;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6 unexpected frame", int'(fr), 0);
                end else begin
                    expf = {1'b1, exp_q.pop_front(), 1'b0};
                    check(fr == expf, tag_q.pop_front(), int'(fr), int'(expf));
                end
            end
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (rst_n) take_bit(ser_out);
            #10;
            if (rst_n) take_bit(ser_out);
        end
    end

    task automatic wait_ready();
        int n = 0;
        while (ready !== 1'b1 && n < 100) begin
            @(posedge clk);
            #5;
            n++;
        end
    endtask

    // Driver: pushes the expected address, then pulses the strobes for one edge.
    task automatic fire(input logic [N_CH-1:0] vec, input logic [AW-1:0] exp_addr, input string tag);
        int lows;
        exp_q.push_back(exp_addr);
        tag_q.push_back(tag);
        @(negedge clk);
        hit = vec;
        @(posedge clk);
        #5;
        hit = '0;
        check(ready == 1'b0, "R2 ready low after capture", int'(ready), 0);
        lows = 1;
        forever begin
            @(posedge clk);
            #5;
            if (ready === 1'b1 || lows > 50) break;
            lows++;
        end
        check(lows == BUSY_CYC, "R7 busy cycles", lows, BUSY_CYC);
        check(dbg_addr == exp_addr, "R3 debug address", int'(dbg_addr), int'(exp_addr));
        // R5: line stays low once armed again
        #0;
        check(ser_out == 1'b0, "R5 idle high phase", int'(ser_out), 0);
        #10;
        check(ser_out == 1'b0, "R5 idle low phase", int'(ser_out), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #5;
        // R1: reset state
        check(ready == 1'b1, "R1 ready in reset", int'(ready), 1);
        check(ser_out == 1'b0, "R1 line in reset", int'(ser_out), 0);
        check(dbg_addr == '0, "R1 debug addr in reset", int'(dbg_addr), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #5;
        check(ready == 1'b1 && ser_out == 1'b0, "R1 after release", int'(ready), 1);

        fire(N_CH'(1) << 5,  6'd5,  "R4 single ch5");
        fire(N_CH'(1),       6'd0,  "R4 ch0");
        fire(N_CH'(1) << 63, 6'd63, "R4 ch63");
        fire((N_CH'(1) << 42) | (N_CH'(1) << 21), 6'd21, "R3 pair 21/42");
        fire((N_CH'(1) << 3) | (N_CH'(1) << 17) | (N_CH'(1) << 40), 6'd3, "R3 triple");
        fire((N_CH'(1) << 62) | (N_CH'(1) << 63), 6'd62, "R3 top pair");
        fire('1, 6'd0, "R3 all channels");
        fire({32{2'b10}}, 6'd1, "R3 alternating");
        fire(N_CH'(1) << 42, 6'd42, "R4 ch42 pattern");

        // R6: strobes during send and recovery are dropped
        exp_q.push_back(6'd10);
        tag_q.push_back("R6 first hit kept");
        @(negedge clk);
        hit = N_CH'(1) << 10;
        @(posedge clk);
        #5;
        hit = N_CH'(1) << 2;
        @(posedge clk);
        #5;
        hit = '0;
        repeat (4) @(posedge clk);
        #5;
        hit = N_CH'(1) << 7;
        repeat (2) @(posedge clk);
        #5;
        hit = '0;
        check(ready == 1'b0, "R6 still busy", int'(ready), 0);
        wait_ready();
        check(ready == 1'b1, "R7 rearmed", int'(ready), 1);
        check(dbg_addr == 6'd10, "R6 debug addr kept", int'(dbg_addr), 10);
        repeat (12) @(posedge clk);
        #5;
        check(ready == 1'b1, "R6 no late capture", int'(ready), 1);
        check(dbg_addr == 6'd10, "R6 addr untouched", int'(dbg_addr), 10);

        // R7: next hit accepted straight after rearm
        fire(N_CH'(1) << 33, 6'd33, "R7 next hit accepted");

        repeat (6) @(posedge clk);
        check(exp_q.size() == 0, "R4 missing frames", exp_q.size(), 0);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule